// File: doc/BRIEF.md
# Integer ALU with Bitfield Operations

A purely combinational integer execution unit for the execute stage of a 32-bit RISC-style core. Each cycle the core presents an operation code, two register operands, an immediate shift amount and a bitfield position/length pair. The unit returns a result word and a register write-enable in the same cycle. It covers wrapping add and subtract, the bitwise logic family, signed and unsigned compare-to-flag, upper-immediate load, fixed and variable shifts, rotate, sign extension, a byte swap inside each halfword, bitfield extract and insert, count leading zeros, and conditional moves that can cancel the register write.

The unit holds no state. The surrounding pipeline selects the operands. For an insert it passes the old destination value on `opnd_b` and the source field on `opnd_a`. For a conditional move it passes the value to move on `opnd_a` and the value to test on `opnd_b`.

Top module: `int_bitfield_alu`

## Requirements
- R1: ADD (op 0) returns a+b and SUB (op 1) returns a-b, both modulo 2^W, with no overflow indication.
- R2: AND (op 2), OR (op 3), XOR (op 4) and NOR (op 5) return the bitwise result of a and b. NOR is the inverted OR.
- R3: SLT (op 6) returns 1 if a<b as two's-complement values and 0 otherwise. SLTU (op 7) does the same for unsigned values. Every bit above bit 0 is zero.
- R4: LUI (op 8) places b[15:0] in the top 16 bits of the result and zeroes every lower bit.
- R5: SLL (op 9), SRL (op 10) and SRA (op 11) shift b by `shamt`. Left and logical right shifts fill with zeros. The arithmetic right shift fills with copies of b[W-1].
- R6: SLLV (op 12), SRLV (op 13) and SRAV (op 14) shift b like R5, by the amount in a[4:0] only. The upper bits of a have no effect.
- R7: ROTR (op 15) rotates b right by `shamt` and ROTRV (op 16) rotates it right by a[4:0]. Bits leaving bit 0 re-enter at bit W-1.
- R8: SEB (op 17) copies b[7] into bits W-1:8 and keeps b[7:0]. SEH (op 18) copies b[15] into bits W-1:16 and keeps b[15:0].
- R9: WSBH (op 19) swaps the two bytes within every 16-bit halfword of b. For W=32 the result is {b[23:16], b[31:24], b[7:0], b[15:8]}.
- R10: EXT (op 20) returns the bits a[pos+len-1:pos], zero-extended to W bits. Positions at or above W read as zero. A length of 0 returns 0. Lengths above W act as W.
- R11: INS (op 21) returns b with bits pos..pos+len-1 replaced by the low bits of a. Bit positions at or above W are dropped, and every other bit of b is kept. A length of 0 returns b unchanged.
- R12: CLZ (op 22) returns the number of zero bits above the most significant 1 of a, and returns W when a is zero.
- R13: MOVN (op 23) and MOVZ (op 24) return a. The write-enable is high for MOVN only when b is nonzero, and for MOVZ only when b is zero.
- R14: All other operations (ops 0 to 22) raise the write-enable. Codes 25 to 31 return 0 with the write-enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation code |
| opnd_a | input | W | First operand: insert source, variable shift amount, value to move |
| opnd_b | input | W | Second operand: shifted value, old destination, move test value |
| shamt | input | SW | Immediate shift or rotate amount |
| bf_pos | input | SW | Lowest bit of the bitfield |
| bf_len | input | SW+1 | Bitfield length in bits |
| result | output | W | Result word |
| wr_en | output | 1 | Register write-enable |

## Verification
The bench builds the unit with its defaults, W=32 and therefore SW=5. At these widths every shift and rotate amount from 0 to 31 can occur, and the 6-bit length field reaches values from 33 to 63. Those values, together with positions near the top of the word, exercise the truncation rules for extract and insert that the R10 and R11 requirements define. Random operation codes span all 32 encodings, so the undefined codes and the cancelled-write cases of the conditional moves are hit many times besides the directed corners.

// File: rtl/int_bitfield_alu.sv
module int_bitfield_alu #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [4:0]    op,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [SW-1:0] shamt,
  input  logic [SW-1:0] bf_pos,
  input  logic [SW:0]   bf_len,
  output logic [W-1:0]  result,
  output logic          wr_en
);

  localparam int BYTE = 8;
  localparam int HALF = 16;
  localparam int NHALF = W / HALF;

  localparam logic [4:0] OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_AND  = 5'd2,  OP_OR   = 5'd3;
  localparam logic [4:0] OP_XOR  = 5'd4,  OP_NOR  = 5'd5,  OP_SLT  = 5'd6,  OP_SLTU = 5'd7;
  localparam logic [4:0] OP_LUI  = 5'd8,  OP_SLL  = 5'd9,  OP_SRL  = 5'd10, OP_SRA  = 5'd11;
  localparam logic [4:0] OP_SLLV = 5'd12, OP_SRLV = 5'd13, OP_SRAV = 5'd14, OP_ROTR = 5'd15;
  localparam logic [4:0] OP_ROTV = 5'd16, OP_SEB  = 5'd17, OP_SEH  = 5'd18, OP_WSBH = 5'd19;
  localparam logic [4:0] OP_EXT  = 5'd20, OP_INS  = 5'd21, OP_CLZ  = 5'd22, OP_MOVN = 5'd23;
  localparam logic [4:0] OP_MOVZ = 5'd24;

  logic [SW-1:0]  vamt;
  logic [2*W-1:0] rot_fix, rot_var;
  logic [W-1:0]   swapped;
  logic [W:0]     one_sh;
  logic [W-1:0]   len_mask, fld_mask;

  assign vamt    = opnd_a[SW-1:0];
  assign rot_fix = {opnd_b, opnd_b} >> shamt;
  assign rot_var = {opnd_b, opnd_b} >> vamt;

  genvar h;
  generate
    for (h = 0; h < NHALF; h++) begin : g_swap
      assign swapped[h*HALF +: BYTE]      = opnd_b[h*HALF+BYTE +: BYTE];
      assign swapped[h*HALF+BYTE +: BYTE] = opnd_b[h*HALF +: BYTE];
    end
  endgenerate

  assign one_sh   = (W+1)'(1) << bf_len;
  assign len_mask = (32'(bf_len) >= W) ? '1 : (one_sh[W-1:0] - W'(1));
  assign fld_mask = len_mask << bf_pos;

  logic [SW:0] lz;

  always_comb begin
    lz = SW'(0) + (SW+1)'(W);
    for (int i = 0; i < W; i++)
      if (opnd_a[i]) lz = (SW+1)'(W - 1 - i);

    wr_en = 1'b1;
    case (op)
      OP_ADD:  result = opnd_a + opnd_b;
      OP_SUB:  result = opnd_a - opnd_b;
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      OP_XOR:  result = opnd_a ^ opnd_b;
      OP_NOR:  result = ~(opnd_a | opnd_b);
      OP_SLT:  result = W'($signed(opnd_a) < $signed(opnd_b));
      OP_SLTU: result = W'(opnd_a < opnd_b);
      OP_LUI:  result = {opnd_b[HALF-1:0], {(W-HALF){1'b0}}};
      OP_SLL:  result = opnd_b << shamt;
      OP_SRL:  result = opnd_b >> shamt;
      OP_SRA:  result = $unsigned($signed(opnd_b) >>> shamt);
      OP_SLLV: result = opnd_b << vamt;
      OP_SRLV: result = opnd_b >> vamt;
      OP_SRAV: result = $unsigned($signed(opnd_b) >>> vamt);
      OP_ROTR: result = rot_fix[W-1:0];
      OP_ROTV: result = rot_var[W-1:0];
      OP_SEB:  result = {{(W-BYTE){opnd_b[BYTE-1]}}, opnd_b[BYTE-1:0]};
      OP_SEH:  result = {{(W-HALF){opnd_b[HALF-1]}}, opnd_b[HALF-1:0]};
      OP_WSBH: result = swapped;
      OP_EXT:  result = (opnd_a >> bf_pos) & len_mask;
      OP_INS:  result = (opnd_b & ~fld_mask) | ((opnd_a << bf_pos) & fld_mask);
      OP_CLZ:  result = W'(lz);
      OP_MOVN: begin result = opnd_a; wr_en = (opnd_b != '0); end
      OP_MOVZ: begin result = opnd_a; wr_en = (opnd_b == '0); end
      default: begin result = '0; wr_en = 1'b0; end
    endcase

    if (!$isunknown({op, opnd_a, opnd_b, shamt, bf_pos, bf_len})) begin
      a_r3_flag_only_bit0: assert (!(op == OP_SLT || op == OP_SLTU) || result[W-1:1] == '0);
      a_r4_lui_low_clear:  assert (op != OP_LUI || result[W-HALF-1:0] == '0);
      a_r10_ext_high_zero: assert (op != OP_EXT || 32'(bf_len) >= W || (result >> bf_len) == '0);
      a_r12_clz_bounded:   assert (op != OP_CLZ || result <= W);
      a_r13_move_value:    assert (!(op == OP_MOVN || op == OP_MOVZ) || result == opnd_a);
      a_r14_undef_silent:  assert (op <= OP_MOVZ || (result == '0 && !wr_en));
    end
  end

endmodule

// File: tb/int_bitfield_alu_bench.sv
module int_bitfield_alu_bench;
  localparam int W = 32;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]    op;
  logic [W-1:0]  a, b;
  logic [SW-1:0] shamt, pos;
  logic [SW:0]   len;
  logic [W-1:0]  result;
  logic          wr_en;

  int_bitfield_alu #(.W(W), .SW(SW)) u_int_bitfield_alu (
    .op(op), .opnd_a(a), .opnd_b(b), .shamt(shamt), .bf_pos(pos), .bf_len(len),
    .result(result), .wr_en(wr_en)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic string tag(input logic [4:0] o);
    case (o)
      0, 1: return "R1";
      2, 3, 4, 5: return "R2";
      6, 7: return "R3";
      8: return "R4";
      9, 10, 11: return "R5";
      12, 13, 14: return "R6";
      15, 16: return "R7";
      17, 18: return "R8";
      19: return "R9";
      20: return "R10";
      21: return "R11";
      22: return "R12";
      23, 24: return "R13";
      default: return "R14";
    endcase
  endfunction

  function automatic logic [W:0] model(input logic [4:0] o, input logic [W-1:0] x, y,
                                       input int sh, input int p, input int l);
    logic [W-1:0] r;
    logic we;
    int va, cnt;
    we = 1'b1;
    r = '0;
    va = int'(x[4:0]);
    case (o)
      0: r = x + y;
      1: r = x - y;
      2: r = x & y;
      3: r = x | y;
      4: r = x ^ y;
      5: r = ~(x | y);
      6: r = ($signed(x) < $signed(y)) ? 1 : 0;
      7: r = (x < y) ? 1 : 0;
      8: r = {y[15:0], 16'h0};
      9, 12: begin int s = (o == 9) ? sh : va; for (int i = 0; i < W; i++) r[i] = (i >= s) ? y[i-s] : 1'b0; end
      10, 13: begin int s = (o == 10) ? sh : va; for (int i = 0; i < W; i++) r[i] = (i + s < W) ? y[i+s] : 1'b0; end
      11, 14: begin int s = (o == 11) ? sh : va; for (int i = 0; i < W; i++) r[i] = (i + s < W) ? y[i+s] : y[W-1]; end
      15, 16: begin int s = (o == 15) ? sh : va; for (int i = 0; i < W; i++) r[i] = y[(i+s)%W]; end
      17: begin r = y; for (int i = 8; i < W; i++) r[i] = y[7]; end
      18: begin r = y; for (int i = 16; i < W; i++) r[i] = y[15]; end
      19: r = {y[23:16], y[31:24], y[7:0], y[15:8]};
      20: for (int i = 0; i < W; i++) if (i < l && p + i < W) r[i] = x[p+i];
      21: begin r = y; for (int i = 0; i < W; i++) if (i < l && p + i < W) r[p+i] = x[i]; end
      22: begin cnt = 0; for (int i = W - 1; i >= 0; i--) begin if (x[i]) break; cnt++; end r = cnt; end
      23: begin r = x; we = (y != 0); end
      24: begin r = x; we = (y == 0); end
      default: begin r = '0; we = 1'b0; end
    endcase
    return {we, r};
  endfunction

  task automatic apply(input logic [4:0] o, input logic [W-1:0] x, y,
                       input int sh, input int p, input int l);
    logic [W:0] exp;
    @(negedge clk);
    op = o; a = x; b = y; shamt = SW'(sh); pos = SW'(p); len = (SW+1)'(l);
    #1;
    exp = model(o, x, y, sh, p, l);
    n_vec++;
    if ({wr_en, result} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d pos=%0d len=%0d: got we=%b res=%h, expected we=%b res=%h",
               tag(o), o, x, y, sh, p, l, wr_en, result, exp[W], exp[W-1:0]);
    end
  endtask

  initial begin
    int unsigned seed;
    op = 0; a = 0; b = 0; shamt = 0; pos = 0; len = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-time state: zero operands, add
    apply(0, 0, 0, 0, 0, 0);
    // R1 wrap
    apply(0, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
    apply(1, 32'h0, 32'h1, 0, 0, 0);
    // R2
    apply(5, 32'hF0F0_0000, 32'h0000_0F0F, 0, 0, 0);
    // R3 signed vs unsigned
    apply(6, 32'h8000_0000, 32'h1, 0, 0, 0);
    apply(7, 32'h8000_0000, 32'h1, 0, 0, 0);
    // R4
    apply(8, 32'h0, 32'h1234_ABCD, 0, 0, 0);
    // R5 sign fill
    apply(11, 32'h0, 32'h8000_0000, 31, 0, 0);
    apply(10, 32'h0, 32'h8000_0000, 31, 0, 0);
    // R6 low five bits only
    apply(12, 32'hFFFF_FFE5, 32'h1, 0, 0, 0);
    apply(14, 32'h0000_0104, 32'h8000_0000, 0, 0, 0);
    // R7
    apply(15, 32'h0, 32'h1, 1, 0, 0);
    apply(16, 32'h0000_0020, 32'h1234_5678, 0, 0, 0);
    // R8
    apply(17, 32'h0, 32'h0000_0080, 0, 0, 0);
    apply(18, 32'h0, 32'h0000_8000, 0, 0, 0);
    // R9
    apply(19, 32'h0, 32'h1122_3344, 0, 0, 0);
    // R10 truncation, zero length, overlong length
    apply(20, 32'hABCD_EF12, 32'h0, 0, 28, 8);
    apply(20, 32'hABCD_EF12, 32'h0, 0, 4, 0);
    apply(20, 32'hABCD_EF12, 32'h0, 0, 0, 63);
    // R11
    apply(21, 32'h0000_00A5, 32'hFFFF_FFFF, 0, 4, 8);
    apply(21, 32'h1234_5678, 32'hFFFF_FFFF, 0, 0, 32);
    apply(21, 32'h0000_000F, 32'h0, 0, 30, 4);
    apply(21, 32'h1234_5678, 32'hCAFE_BABE, 0, 9, 0);
    // R12
    apply(22, 32'h0, 32'h0, 0, 0, 0);
    apply(22, 32'h1, 32'h0, 0, 0, 0);
    apply(22, 32'h8000_0000, 32'h0, 0, 0, 0);
    // R13 suppressed and granted writes
    apply(23, 32'hDEAD_BEEF, 32'h0, 0, 0, 0);
    apply(24, 32'hDEAD_BEEF, 32'h0, 0, 0, 0);
    apply(23, 32'hDEAD_BEEF, 32'h4, 0, 0, 0);
    // R14 undefined codes
    apply(25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 3, 3);
    apply(31, 32'h1, 32'h0, 0, 0, 0);
    seed = $urandom(32'h1F2E3D4C);
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] ra, rb;
      ra = ($urandom % 8 == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
      rb = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      apply(5'($urandom % 32), ra, rb, int'($urandom % 32), int'($urandom % 32), int'($urandom % 64));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: got timeout at cycle %0d, expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end
endmodule